// File: doc/BRIEF.md
# Clock Frequency Meter

This block measures how fast one of several monitored clocks runs compared with a fixed reference clock. Software programs a 32-bit control word that chooses a monitored clock, sets a cycle count, and carries a mode bit and a lock threshold. Setting the detect-enable bit starts a run. The block counts reference-clock cycles while the chosen monitored clock produces the programmed number of rising edges. It then posts that count as the result and raises a valid flag. The monitored frequency is the reference frequency times the cycle count, divided by the result.

Each monitored clock has its own edge counter in its own clock domain. The counter is armed through a two-flop synchronizer. When it reaches the programmed count it flips a toggle, and that toggle is synchronized back into the reference domain. The result reads zero until a run completes, so software can poll it for a non-zero value. Clearing detect-enable before completion aborts the run and rearms the meter. A separate status bit drives an enable output for an external free-running clock gate. A synchronized copy of a PLL lock input is reported beside the valid flag.

Top module: `clk_freq_meter`

## Requirements
- R1: A control write stores all 32 bits and reads them back unchanged. The fields are: lock threshold in bits 31:28, monitor select in bits 27:26, mode in bit 25, detect-enable in bit 24, cycle count in bits 23:0.
- R2: The monitor select value is the index of the measured clock: 0 measures `mon_clk[0]`, 1 measures `mon_clk[1]`.
- R3: A control write that takes detect-enable from 0 to 1 clears the result and the valid flag on that same clock edge.
- R4: On completion the result equals the number of reference cycles from the start edge until the completion is seen. This lies between cycle_count × T_mon / T_ref and that value plus 16.
- R5: On completion, status bit 0 (valid) goes to 1. Result and valid then stay unchanged, even after detect-enable is cleared, until the next 0-to-1 transition of detect-enable.
- R6: Clearing detect-enable before completion aborts the run. Valid stays 0, the result stays 0, and a later start measures normally.
- R7: Starting with a cycle count of zero finishes at once. The result is 0 and valid stays 0.
- R8: The result saturates at all ones (2^RES_W − 1) instead of wrapping, and valid is still set on completion.
- R9: A free-run write sets status bit 8 and drives `frc_en_o` to the same value on the next clock. Valid in status bit 0 does not change.
- R10: Status bit 1 follows `pll_lock_i` through two reference-clock flops. A change shows after the second rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| mon_clk | input | NUM_MON | Monitored clocks |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| frc_we | input | 1 | Free-run enable write strobe |
| frc_wdata | input | 1 | Free-run enable write value |
| cfg_rdata | output | 32 | Control word readback |
| stat_rdata | output | 32 | Status: bit 8 free-run enable, bit 1 lock, bit 0 valid |
| result_o | output | RES_W | Measured reference-cycle count |
| frc_en_o | output | 1 | Free-running clock gate enable |

## Verification
The bench builds the meter with NUM_MON = 2 and RES_W = 12. The reference runs at 4 ns, `mon_clk[0]` at 6 ns and `mon_clk[1]` at 10 ns. A 12-bit result holds a 1024-cycle measurement of the faster clock. It saturates on a 2048-cycle measurement of the slower one, so R8 is reached in a few thousand cycles. The two monitored periods differ, so a wrong select decode shows up as a result outside the expected window. Short counts of 64 and 256 cycles exercise rearming after an abort.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int CYC_W = 24;
  localparam int SEL_W = 2;

  localparam int STAT_FRC_BIT  = 8;
  localparam int STAT_LOCK_BIT = 1;
  localparam int STAT_VLD_BIT  = 0;

  typedef struct packed {
    logic [3:0]       lock_thr;
    logic [SEL_W-1:0] mon_sel;
    logic             mode;
    logic             det_en;
    logic [CYC_W-1:0] cyc_cnt;
  } fm_ctrl_t;

  function automatic logic [31:0] pack_status(input logic frc, input logic lock, input logic vld);
    logic [31:0] s;
    s = '0;
    s[STAT_FRC_BIT]  = frc;
    s[STAT_LOCK_BIT] = lock;
    s[STAT_VLD_BIT]  = vld;
    return s;
  endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
  parameter int CNT_W = 24
) (
  input  logic             mon_clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_tgl_o
);
  logic             arm_s;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             done_q;
  logic             tgl_q;
  logic             hit;

  fm_sync #(.W(1)) u_arm_sync (
    .clk   (mon_clk),
    .rst_n (rst_n),
    .d_i   (arm_i),
    .q_o   (arm_s)
  );

  assign cnt_nxt = cnt_q + 1'b1;
  assign hit     = arm_s & ~done_q & (cnt_nxt == target_i);

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (!arm_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_nxt;
      if (hit) begin
        done_q <= 1'b1;
        tgl_q  <= ~tgl_q;
      end
    end
  end

  assign done_tgl_o = tgl_q;

  // R4: one completion toggle per armed run
  p_single_toggle_r4: assert property (@(posedge mon_clk) disable iff (!rst_n)
    done_q |=> $stable(tgl_q));
  // R6: disarming clears the edge count
  p_disarm_clears_r6: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !arm_s |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/fm_ref_timer.sv
module fm_ref_timer #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cyc_nz_i,
  input  logic             done_evt_i,
  output logic             run_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  logic [RES_W-1:0] cnt_q;
  logic             run_q;
  logic [RES_W-1:0] res_q;
  logic             vld_q;
  logic             finish;

  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign finish = run_q & ~stop_i & done_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
      run_q <= cyc_nz_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (finish) begin
        res_q <= cnt_q;
        vld_q <= 1'b1;
        run_q <= 1'b0;
      end else begin
        cnt_q <= sat_inc(cnt_q);
      end
    end
  end

  assign run_o    = run_q;
  assign result_o = res_q;
  assign valid_o  = vld_q;

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (res_q == '0) && !vld_q);
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !start_i) |=> vld_q && $stable(res_q));
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && run_q) |=> !run_q && !vld_q);
  p_zero_cyc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cyc_nz_i) |=> !run_q && !vld_q);
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_q) && !start_i) |=> (&cnt_q));
  p_valid_from_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(done_evt_i));
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import fm_pkg::*;
#(
  parameter int NUM_MON = 2,
  parameter int RES_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_clk,
  input  logic               pll_lock_i,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic               frc_we,
  input  logic               frc_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [31:0]        stat_rdata,
  output logic [RES_W-1:0]   result_o,
  output logic               frc_en_o
);
  fm_ctrl_t         cfg_q;
  fm_ctrl_t         wr_ctrl;
  logic             frc_q;
  logic             lock_s;
  logic [SEL_W-1:0] sel_q;
  logic [CYC_W-1:0] cyc_q;
  logic             start_evt;
  logic             stop_evt;
  logic             run;
  logic             valid;
  logic             done_evt;
  logic [NUM_MON-1:0] arm_vec;
  logic [NUM_MON-1:0] tgl_vec;
  logic [NUM_MON-1:0] tgl_s;
  logic [NUM_MON-1:0] tgl_prev;
  logic [NUM_MON-1:0] edge_vec;

  assign wr_ctrl   = fm_ctrl_t'(cfg_wdata);
  assign start_evt = cfg_we & wr_ctrl.det_en & ~cfg_q.det_en;
  assign stop_evt  = cfg_we & ~wr_ctrl.det_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      frc_q <= 1'b0;
      sel_q <= '0;
      cyc_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= wr_ctrl;
      if (frc_we) frc_q <= frc_wdata;
      if (start_evt) begin
        sel_q <= wr_ctrl.mon_sel;
        cyc_q <= wr_ctrl.cyc_cnt;
      end
    end
  end

  fm_sync #(.W(1)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pll_lock_i),
    .q_o   (lock_s)
  );

  fm_sync #(.W(NUM_MON)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (tgl_vec),
    .q_o   (tgl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_prev <= '0;
    else        tgl_prev <= tgl_s;
  end

  assign edge_vec = tgl_s ^ tgl_prev;

  for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
    assign arm_vec[i] = run & (sel_q == IDX);

    fm_edge_counter #(.CNT_W(CYC_W)) u_cnt (
      .mon_clk    (mon_clk[i]),
      .rst_n      (rst_n),
      .arm_i      (arm_vec[i]),
      .target_i   (cyc_q),
      .done_tgl_o (tgl_vec[i])
    );
  end

  always_comb begin
    done_evt = 1'b0;
    for (int k = 0; k < NUM_MON; k++) begin
      if (sel_q == SEL_W'(k)) done_evt = edge_vec[k];
    end
  end

  fm_ref_timer #(.RES_W(RES_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .cyc_nz_i   (|wr_ctrl.cyc_cnt),
    .done_evt_i (done_evt),
    .run_o      (run),
    .result_o   (result_o),
    .valid_o    (valid)
  );

  assign cfg_rdata  = cfg_q;
  assign stat_rdata = pack_status(frc_q, lock_s, valid);
  assign frc_en_o   = frc_q;

  p_cfg_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
  p_arm_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arm_vec));
  p_frc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frc_we |=> frc_en_o == $past(frc_wdata));
endmodule

// File: tb/test_clk_freq_meter.sv
module test_clk_freq_meter;
  localparam int NUM_MON = 2;
  localparam int RES_W   = 12;
  localparam int TREF_PS = 4000;
  localparam int TM0_PS  = 6000;
  localparam int TM1_PS  = 10000;
  localparam int SLACK   = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_MON-1:0] mon_clk = '0;
  logic               pll_lock_i = 1'b0;
  logic               cfg_we = 1'b0;
  logic [31:0]        cfg_wdata = '0;
  logic               frc_we = 1'b0;
  logic               frc_wdata = 1'b0;
  logic [31:0]        cfg_rdata;
  logic [31:0]        stat_rdata;
  logic [RES_W-1:0]   result_o;
  logic               frc_en_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct { int lo; int hi; string tag; } exp_t;
  exp_t exp_q[$];

  always #2ns clk = ~clk;
  always #3ns mon_clk[0] = ~mon_clk[0];
  always #5ns mon_clk[1] = ~mon_clk[1];

  clk_freq_meter #(.NUM_MON(NUM_MON), .RES_W(RES_W)) i_clk_freq_meter (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .pll_lock_i(pll_lock_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .frc_we(frc_we), .frc_wdata(frc_wdata),
    .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata), .result_o(result_o), .frc_en_o(frc_en_o)
  );

  function automatic int est_ref(input int cyc, input int tmon_ps);
    longint v;
    v = longint'(cyc) * tmon_ps / TREF_PS;
    if (v > (2**RES_W) - 1) v = (2**RES_W) - 1;
    return int'(v);
  endfunction

  function automatic logic [31:0] ctl(input int sel, input bit det, input int cyc);
    return {4'h0, 2'(sel), 1'b0, det, 24'(cyc)};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int sel, input int cyc, input int tmon_ps, input string tag);
    exp_t e;
    int b;
    b = est_ref(cyc, tmon_ps);
    e.lo = b;
    e.hi = (b + SLACK > (2**RES_W) - 1) ? (2**RES_W) - 1 : b + SLACK;
    e.tag = tag;
    exp_q.push_back(e);
    cfg_write(ctl(sel, 1'b0, cyc));
    cfg_write(ctl(sel, 1'b1, cyc));
    // R3: one edge after the start write, the result and valid are cleared
    check(result_o == '0 && stat_rdata[0] == 1'b0, "R3 cleared on start", result_o, 0);
    for (int n = 0; n < 20000 && exp_q.size() != 0; n++) @(negedge clk);
    check(exp_q.size() == 0, {tag, " completion seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge stat_rdata[0]);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected valid", result_o, 0);
      end else begin
        e = exp_q.pop_front();
        check(int'(result_o) >= e.lo && int'(result_o) <= e.hi, e.tag, result_o, e.lo);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    logic [RES_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 0 && stat_rdata == 0 && result_o == 0 && !frc_en_o, "R1 reset state", stat_rdata, 0);

    cfg_write(32'hA2000400);
    check(cfg_rdata == 32'hA2000400, "R1 readback", cfg_rdata, 32'hA2000400);
    cfg_write(32'h5D123456);
    check(cfg_rdata == 32'h5D123456, "R1 readback all fields", cfg_rdata, 32'h5D123456);
    cfg_write(32'h0);

    measure(0, 'h400, TM0_PS, "R4 port0 1024 cycles");

    cfg_write(ctl(0, 1'b0, 'h400));
    held = result_o;
    repeat (20) @(negedge clk);
    check(stat_rdata[0] == 1'b1 && result_o == held, "R5 frozen after clear", result_o, held);

    measure(1, 'h100, TM1_PS, "R2 port1 256 cycles");

    cfg_write(ctl(1, 1'b0, 'h400));
    repeat (10) @(negedge clk);
    cfg_write(ctl(1, 1'b1, 'h400));
    repeat (50) @(negedge clk);
    cfg_write(ctl(1, 1'b0, 'h400));
    repeat (3000) @(negedge clk);
    check(stat_rdata[0] == 1'b0 && result_o == 0, "R6 abort keeps valid low", result_o, 0);
    repeat (20) @(negedge clk);
    measure(0, 'h40, TM0_PS, "R6 rearm port0 64 cycles");

    cfg_write(ctl(0, 1'b0, 0));
    cfg_write(ctl(0, 1'b1, 0));
    repeat (200) @(negedge clk);
    check(stat_rdata[0] == 1'b0 && result_o == 0, "R7 zero count", result_o, 0);
    cfg_write(ctl(0, 1'b0, 0));
    repeat (20) @(negedge clk);

    measure(1, 'h800, TM1_PS, "R8 saturation");
    check(result_o == {RES_W{1'b1}}, "R8 saturated value", result_o, (2**RES_W) - 1);

    @(negedge clk);
    frc_we = 1'b1; frc_wdata = 1'b1;
    @(negedge clk);
    frc_we = 1'b0;
    check(frc_en_o && stat_rdata[8] && stat_rdata[0], "R9 free-run on", stat_rdata, 32'h101);
    @(negedge clk);
    frc_we = 1'b1; frc_wdata = 1'b0;
    @(negedge clk);
    frc_we = 1'b0;
    check(!frc_en_o && !stat_rdata[8], "R9 free-run off", frc_en_o, 0);

    @(negedge clk);
    pll_lock_i = 1'b1;
    @(negedge clk);
    check(stat_rdata[1] == 1'b0, "R10 lock after one edge", stat_rdata[1], 0);
    @(negedge clk);
    check(stat_rdata[1] == 1'b1, "R10 lock after two edges", stat_rdata[1], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule